// File: doc/BRIEF.md
# Power-Fail Write Guard with Battery Flag

This block sits between the byte-wide bus of a battery-backed static memory and the memory array itself. It decodes the active-low chip select, write strobe and output enable, turns a bus write window into a single-cycle commit into the array, and decides when the shared data pins may be driven. All bus inputs are sampled on the block clock.

A raw supply-in-tolerance indication passes through a two-flop synchronizer. While the supply is out of tolerance, or while the battery-switchover input reports backup operation, the block deselects the memory. The pins float, bus inputs are ignored, and a write window that overlaps the deselect never commits. A battery-low sample is taken each time the supply comes back into tolerance. A low result raises a battery flag, which swallows the next completed write and then clears. Software can test the battery by writing the complement of a byte and reading it back.

Top module: `pfg_guard`

## Requirements
- R1: `dq_drive` is 1 only while the block is selected and `ce_n`=0, `oe_n`=0 and `we_n`=1. It is 0 in every other case.
- R2: While `ce_n`=1, `mem_cs` and `dq_drive` are 0 and no write commits, whatever `oe_n` and `we_n` are.
- R3: Pulling `we_n` low while `ce_n` and `oe_n` are low turns `dq_drive` off.
- R4: A write window is the run of clock edges that see both `ce_n` and `we_n` at 0. On the first edge that sees either of them at 1, `mem_we` goes high for exactly one cycle. During that cycle, `mem_wr_addr` and `mem_wr_data` hold the `addr` and `wdata` sampled at the last edge of the window.
- R5: The window ends on whichever of `we_n` or `ce_n` rises first, and both orders commit.
- R6: `supply_ok_raw` passes through two flops and then one select register. After it falls, the outputs still act on the bus for two clock edges and are deselected from the third edge on.
- R7: No write commits if its window was open at any edge while the block was deselected. This covers a window opened during the deselect, one cut by it, and one still open when the supply returns.
- R8: `bat_mode`=1 deselects the block from the next clock edge. `mem_cs` and `dq_drive` are then 0.
- R9: When the synchronized supply flag rises and `batt_low`=1, `bok_flag` is set. The next completed write is then discarded (no `mem_we`), `bok_flag` clears, and the write after it commits.
- R10: `batt_low` is sampled only when the supply returns. Later changes to it leave `bok_flag` unchanged, and a return with `batt_low`=0 leaves the flag clear.
- R11: While `rst_n` is low, `mem_cs`, `dq_drive`, `mem_we` and `bok_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok_raw | input | 1 | Unsynchronized supply-in-tolerance indication |
| bat_mode | input | 1 | Supply is below the battery switchover level (synchronous) |
| batt_low | input | 1 | Battery-low sample, taken when the supply returns |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| mem_cs | output | 1 | Array access enable |
| dq_drive | output | 1 | Enable for the data pin drivers |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_wr_addr | output | AW | Address of the committed write |
| mem_wr_data | output | DW | Data of the committed write |
| bok_flag | output | 1 | Battery-not-good flag |

## Verification
The hardest cases to reach from the ports are write windows that straddle a supply transition. One case is a window cut by the loss of supply. The other is a window opened while the supply was out and still held when it returns. To reach them, the stimulus holds `ce_n` and `we_n` low across several cycles and toggles `supply_ok_raw` in the middle, so the three-edge synchronizer latency elapses inside the window. It then counts `mem_we` pulses over the whole episode. The battery flag needs a full supply drop and return with `batt_low` held high. The write that is then swallowed is told apart from the commit that follows it by pulse counts and `bok_flag`.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    WG_IDLE  = 2'd0,
    WG_OPEN  = 2'd1,
    WG_SPOIL = 2'd2
  } wg_state_t;
endpackage

// File: rtl/pfg_sync.sv
// Multi-stage level synchronizer; with d tied high it forms a reset
// synchronizer (asynchronous assert, synchronous release).
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_write_fsm.sv
// Tracks one bus write window; spoils it if the block is deselected.
module pfg_write_fsm
  import pfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic active,
  output logic capture_en,
  output logic commit
);
  wg_state_t state_q, state_d;

  always_comb begin
    state_d    = state_q;
    capture_en = 1'b0;
    commit     = 1'b0;
    case (state_q)
      WG_IDLE: begin
        if (active) begin
          if (sel) begin
            state_d    = WG_OPEN;
            capture_en = 1'b1;
          end else begin
            state_d = WG_SPOIL;
          end
        end
      end
      WG_OPEN: begin
        if (!sel) begin
          state_d = WG_SPOIL;
        end else if (active) begin
          capture_en = 1'b1;
        end else begin
          commit  = 1'b1;
          state_d = WG_IDLE;
        end
      end
      WG_SPOIL: begin
        if (!active) state_d = WG_IDLE;
      end
      default: state_d = WG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WG_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pfg_guard.sv
module pfg_guard #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok_raw,
  input  logic          bat_mode,
  input  logic          batt_low,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          mem_cs,
  output logic          dq_drive,
  output logic          mem_we,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          bok_flag
);
  localparam int RST_LEN = SYNC_LEN;

  logic rst_n_i;
  logic sup_s;
  logic sup_d_q;
  logic sel_q, sel_d;
  logic bok_q, bok_d;
  logic we_q,  we_d;
  logic [AW-1:0] cap_addr_q, cap_addr_d;
  logic [DW-1:0] cap_data_q, cap_data_d;
  logic active;
  logic capture_en;
  logic commit;
  logic power_up;

  pfg_sync #(.STAGES(RST_LEN)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i)
  );

  pfg_sync #(.STAGES(SYNC_LEN)) u_sup_sync (
    .clk(clk), .rst_n(rst_n_i), .d(supply_ok_raw), .q(sup_s)
  );

  assign active = ~ce_n & ~we_n;

  pfg_write_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .sel(sel_q), .active(active),
    .capture_en(capture_en), .commit(commit)
  );

  // next-state logic
  always_comb begin
    power_up   = sup_s & ~sup_d_q;
    sel_d      = sup_s & ~bat_mode;
    we_d       = commit & ~bok_q;
    bok_d      = bok_q;
    if (power_up)            bok_d = batt_low;
    else if (commit & bok_q) bok_d = 1'b0;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    if (capture_en) begin
      cap_addr_d = addr;
      cap_data_d = wdata;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sup_d_q <= 1'b0;
      sel_q   <= 1'b0;
      bok_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      sup_d_q <= sup_s;
      sel_q   <= sel_d;
      bok_q   <= bok_d;
      we_q    <= we_d;
    end
  end

  // capture registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else if (capture_en) begin
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
    end
  end

  assign mem_cs      = sel_q & ~ce_n;
  assign dq_drive    = mem_cs & ~oe_n & we_n;
  assign mem_we      = we_q;
  assign mem_wr_addr = cap_addr_q;
  assign mem_wr_data = cap_data_q;
  assign bok_flag    = bok_q;
endmodule

// File: rtl/pfg_guard_chk.sv
module pfg_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic mem_cs,
  input logic dq_drive,
  input logic mem_we,
  input logic bok_flag,
  input logic sel_q
);
  p_drive_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (!ce_n && !oe_n && we_n));

  p_ce_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!mem_cs && !dq_drive));

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_we_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(we_n || ce_n));

  p_we_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(sel_q));

  p_bok_swallow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bok_flag) |-> !mem_we);
endmodule

bind pfg_guard pfg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .mem_cs(mem_cs), .dq_drive(dq_drive), .mem_we(mem_we),
  .bok_flag(bok_flag), .sel_q(sel_q)
);

// File: tb/tb_pfg_guard.sv
`timescale 1ns/1ps
module tb_pfg_guard;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, supply_ok_raw, bat_mode, batt_low, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic mem_cs, dq_drive, mem_we, bok_flag;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;

  always #2.5 clk = ~clk;

  pfg_guard #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(supply_ok_raw),
    .bat_mode(bat_mode), .batt_low(batt_low), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .mem_cs(mem_cs),
    .dq_drive(dq_drive), .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .bok_flag(bok_flag)
  );

  always @(negedge clk) if (mem_we === 1'b1) we_cnt++;

  // fields: bat_mode, ce_n, oe_n, we_n, exp dq_drive, exp mem_cs
  localparam logic [5:0] VEC [0:9] = '{
    6'b0_1_0_1_0_0, 6'b0_1_0_0_0_0, 6'b0_0_0_1_1_1, 6'b0_0_1_1_0_1,
    6'b0_0_0_0_0_1, 6'b0_0_1_0_0_1, 6'b1_0_0_1_0_0, 6'b1_1_0_1_0_0,
    6'b0_0_0_1_1_1, 6'b1_0_0_0_0_0
  };
  localparam string VEC_REQ [0:9] = '{
    "R2", "R2", "R1", "R1", "R3", "R1", "R8", "R8", "R1", "R8"
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // mode 0: W rises first, 1: E rises first, 2: both together
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int hold, input int mode, input bit exp,
                          input string req);
    int base;
    base = we_cnt;
    addr = ~a; wdata = ~d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    cyc(hold);
    addr = a; wdata = d;
    cyc(1);
    if (mode == 0) we_n = 1'b1;
    else if (mode == 1) ce_n = 1'b1;
    else begin we_n = 1'b1; ce_n = 1'b1; end
    cyc(1);
    chk(req, {31'd0, mem_we}, {31'd0, exp});
    if (exp) begin
      chk(req, {21'd0, mem_wr_addr}, {21'd0, a});
      chk(req, {24'd0, mem_wr_data}, {24'd0, d});
    end
    bus_idle();
    cyc(2);
    chk(req, we_cnt - base, exp ? 1 : 0);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; supply_ok_raw = 1'b1; bat_mode = 1'b0; batt_low = 1'b0;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = '0; wdata = '0;
    cyc(4);
    // R11 reset state, even with a read requested on the bus
    chk("R11", {28'd0, mem_cs, dq_drive, mem_we, bok_flag}, 32'd0);
    rst_n = 1'b1;
    bus_idle();
    cyc(8);
    chk("R10", {31'd0, bok_flag}, 32'd0);

    // decode table
    for (int i = 0; i < 10; i++) begin
      bat_mode = VEC[i][5]; ce_n = VEC[i][4]; oe_n = VEC[i][3]; we_n = VEC[i][2];
      cyc(2);
      chk(VEC_REQ[i], {30'd0, dq_drive, mem_cs}, {30'd0, VEC[i][1], VEC[i][0]});
    end
    bat_mode = 1'b0; bus_idle();
    cyc(3);

    // R4 / R5 write commits, both end orders
    do_write(11'h7F9, 8'hA5, 3, 0, 1'b1, "R4");
    do_write(11'h123, 8'h3C, 1, 1, 1'b1, "R5");
    do_write(11'h000, 8'hFF, 2, 2, 1'b1, "R4");

    // R6 synchronizer latency during a read
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(1);
    supply_ok_raw = 1'b0;
    cyc(2);
    chk("R6", {31'd0, dq_drive}, 32'd1);
    cyc(1);
    chk("R6", {31'd0, dq_drive}, 32'd0);
    chk("R6", {31'd0, mem_cs}, 32'd0);
    bus_idle();
    supply_ok_raw = 1'b1;
    cyc(6);

    // R7 window cut by supply loss
    base = we_cnt;
    ce_n = 1'b0; we_n = 1'b0; addr = 11'h055; wdata = 8'h11;
    cyc(2);
    supply_ok_raw = 1'b0;
    cyc(5);
    bus_idle();
    cyc(3);
    chk("R7", we_cnt - base, 0);
    // R7 full write while deselected
    do_write(11'h066, 8'h22, 2, 0, 1'b0, "R7");
    // R7 window opened while deselected, supply returns mid-window
    base = we_cnt;
    ce_n = 1'b0; we_n = 1'b0;
    cyc(2);
    supply_ok_raw = 1'b1;
    cyc(6);
    bus_idle();
    cyc(3);
    chk("R7", we_cnt - base, 0);
    do_write(11'h077, 8'h33, 1, 0, 1'b1, "R7");

    // R9 battery flag
    supply_ok_raw = 1'b0;
    cyc(5);
    batt_low = 1'b1;
    supply_ok_raw = 1'b1;
    cyc(6);
    chk("R9", {31'd0, bok_flag}, 32'd1);
    do_write(11'h100, 8'h5A, 2, 0, 1'b0, "R9");
    chk("R9", {31'd0, bok_flag}, 32'd0);
    do_write(11'h100, 8'hA5, 2, 0, 1'b1, "R9");

    // R10 later batt_low activity has no effect
    cyc(20);
    chk("R10", {31'd0, bok_flag}, 32'd0);
    batt_low = 1'b0;
    cyc(3);
    batt_low = 1'b1;
    cyc(3);
    chk("R10", {31'd0, bok_flag}, 32'd0);
    batt_low = 1'b0;
    supply_ok_raw = 1'b0;
    cyc(5);
    supply_ok_raw = 1'b1;
    cyc(6);
    chk("R10", {31'd0, bok_flag}, 32'd0);
    do_write(11'h200, 8'h77, 1, 1, 1'b1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule